// File: doc/BRIEF.md
# Lane Deskew Elastic Buffer

This block lines up the decoded character streams of several serial lanes that belong to one link but reach the receiver at different times. Every lane drops whatever it receives until it meets its first alignment character (the /R/ control character, 0x1C with the K flag set) while its sequence-enable input is high. From that character on, the lane stores its characters in a private FIFO. When the last lane has stored its alignment character, every FIFO begins to drain on the same cycle. The first characters that come out on all lanes together are the alignment characters, so frame boundaries coincide across the output lanes.

The FIFOs are sized to hold a fixed number of frames of octets (`SKEW_FRAMES * OCTETS_PER_FRAME` entries). A lane whose FIFO fills before the link is released means the skew is larger than the buffer can absorb. That condition, and any write into a full FIFO after release, raises a sticky overflow error and forces the outputs invalid. A synchronous link-restart input, or the asynchronous reset, empties every FIFO, clears the error and returns the block to waiting for alignment characters. Decoding, descrambling and lane reordering happen upstream.

Top module: `deskew_buffer`

## Requirements
- R1: After reset, or one cycle after `linkRestart` is sampled high, `outValid`, `linkAligned` and `overflowErr` are 0 and every lane FIFO is empty.
- R2: A lane starts storing at the first character that is valid, has K=1 and value 0x1C, and arrives while that lane's `laneSeqEn` is 1. That character is stored, and so is every valid character after it. Characters before it are dropped.
- R3: A 0x1C character with K=0, or one that arrives while `laneSeqEn` is 0, does not start a lane.
- R4: `linkAligned` goes to 1 on the clock edge that accepts the alignment character of the last lane to start. It stays 1 until reset or restart, unless an overflow occurs.
- R5: One clock edge after `linkAligned` rises, `outValid` is 1 and every lane presents its alignment character (0x1C, K=1) on `outChar`/`outIsK`. From then on, each lane's characters come out in arrival order, one per lane per read.
- R6: A read happens only on a cycle when every lane FIFO holds at least one character. On any other cycle, `outValid` is 0 one edge later.
- R7: A start-time spread between the first and last lane of up to `SKEW_FRAMES*OCTETS_PER_FRAME - 1` cycles (31 at default parameters, one octet per cycle) completes alignment without an overflow.
- R8: If any lane's fill level reaches the FIFO depth at an edge where the link is still unreleased, `overflowErr` becomes 1 and stays 1 until reset or restart. While it is 1, `outValid` and `linkAligned` are 0.
- R9: After release, a valid character arriving at a full lane FIFO on a cycle without a read also sets `overflowErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| linkRestart | input | 1 | Synchronous clear of all FIFOs and state |
| laneValid | input | NUM_LANES | Per-lane character strobe |
| laneChar | input | 8*NUM_LANES | Per-lane decoded character, lane i at bits [8i+7:8i] |
| laneIsK | input | NUM_LANES | Per-lane control-character flag |
| laneSeqEn | input | NUM_LANES | Per-lane alignment-sequence window; alignment characters count only while high |
| outChar | output | 8*NUM_LANES | Aligned characters, same lane packing as the input |
| outIsK | output | NUM_LANES | Aligned control-character flags |
| outValid | output | 1 | Aligned characters present on all lanes |
| linkAligned | output | 1 | All lanes started and no overflow |
| overflowErr | output | 1 | Sticky skew/overflow error |

## Verification
`linkAligned` and `overflowErr` respond on the first edge that samples the causing input, so they are due one cycle after it. Aligned characters take two edges from the last lane's alignment character: one to release the link and one to register the read. A character buffered in a FIFO leaves one edge after the read it belongs to. The bench drives inputs on the falling edge and compares on the next falling edge against a queue model that steps once per rising edge. Each named check is placed at the step these latencies give: the step that drives the last alignment character, the step after it, the step after that, and two steps into an all-lane gap.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  localparam int MAX_LANES = 4;
  localparam logic [7:0] ALIGN_CHAR = 8'h1C;

  typedef struct packed {
    logic                 clear;
    logic                 rdEn;
    logic [MAX_LANES-1:0] wrEn;
  } deskewStrobe_t;
endpackage

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   linkRestart,
  input  logic [NUM_LANES-1:0]   laneValid,
  input  logic [8*NUM_LANES-1:0] laneChar,
  input  logic [NUM_LANES-1:0]   laneIsK,
  input  logic [NUM_LANES-1:0]   laneSeqEn,
  input  logic [CW*NUM_LANES-1:0] laneCount,
  output deskewStrobe_t          strobes,
  output logic                   linkAligned,
  output logic                   overflowErr
);
  logic [NUM_LANES-1:0] writing, hit, wrReq, wrOk, full, nearFull, nonEmpty;
  logic released, relNext, rdEn, dropAny, fillLimit, ovfSet;

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) begin
      hit[i]      = laneValid[i] & laneIsK[i] & laneSeqEn[i] &
                    (laneChar[8*i +: 8] == ALIGN_CHAR) & ~writing[i] & ~overflowErr;
      wrReq[i]    = laneValid[i] & (writing[i] | hit[i]) & ~overflowErr;
      full[i]     = laneCount[CW*i +: CW] == CW'(DEPTH);
      nearFull[i] = laneCount[CW*i +: CW] == CW'(DEPTH - 1);
      nonEmpty[i] = laneCount[CW*i +: CW] != '0;
    end
    relNext   = released | (&(writing | hit));
    rdEn      = released & ~overflowErr & (&nonEmpty);
    wrOk      = wrReq & ~(full & {NUM_LANES{~rdEn}});
    dropAny   = |(wrReq & full) & ~rdEn;
    fillLimit = |(full | (nearFull & wrReq));
    ovfSet    = (~relNext & fillLimit) | dropAny;

    strobes       = '0;
    strobes.clear = linkRestart;
    strobes.rdEn  = rdEn;
    strobes.wrEn[NUM_LANES-1:0] = wrOk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      writing     <= '0;
      released    <= 1'b0;
      overflowErr <= 1'b0;
    end else if (linkRestart) begin
      writing     <= '0;
      released    <= 1'b0;
      overflowErr <= 1'b0;
    end else begin
      writing     <= writing | hit;
      released    <= relNext;
      overflowErr <= overflowErr | ovfSet;
    end
  end

  assign linkAligned = released & ~overflowErr;

  // R4
  releaseHeld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (released && !linkRestart) |=> released);

  // R8
  errSticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflowErr && !linkRestart) |=> overflowErr);

  // R8
  noReadInError_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflowErr |-> !strobes.rdEn);
endmodule

// File: rtl/deskew_lanes.sv
module deskew_lanes
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  deskewStrobe_t           strobes,
  input  logic [8*NUM_LANES-1:0]  laneChar,
  input  logic [NUM_LANES-1:0]    laneIsK,
  output logic [CW*NUM_LANES-1:0] laneCount,
  output logic [8*NUM_LANES-1:0]  outChar,
  output logic [NUM_LANES-1:0]    outIsK,
  output logic                    validReg
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [8:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [8:0]    outReg;
    logic          wr, rd;

    assign wr = strobes.wrEn[g];
    assign rd = strobes.rdEn;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else if (strobes.clear) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(wr) - CW'(rd);
      end
    end

    always_ff @(posedge clk) begin
      if (wr && !strobes.clear) mem[wp] <= {laneIsK[g], laneChar[8*g +: 8]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outReg <= '0;
      else if (rd && !strobes.clear) outReg <= mem[rp];
    end

    assign laneCount[CW*g +: CW] = cnt;
    assign outChar[8*g +: 8]     = outReg[7:0];
    assign outIsK[g]             = outReg[8];

    // R9
    countBound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

    // R6
    readNeedsData_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.rdEn |-> (cnt != '0));

    // R1
    clearEmpties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.clear |=> (cnt == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validReg <= 1'b0;
    else validReg <= strobes.rdEn & ~strobes.clear;
  end
endmodule

// File: rtl/deskew_buffer.sv
module deskew_buffer
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int OCTETS_PER_FRAME = 1,
  parameter int SKEW_FRAMES = 32,
  localparam int DEPTH = SKEW_FRAMES * OCTETS_PER_FRAME,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   linkRestart,
  input  logic [NUM_LANES-1:0]   laneValid,
  input  logic [8*NUM_LANES-1:0] laneChar,
  input  logic [NUM_LANES-1:0]   laneIsK,
  input  logic [NUM_LANES-1:0]   laneSeqEn,
  output logic [8*NUM_LANES-1:0] outChar,
  output logic [NUM_LANES-1:0]   outIsK,
  output logic                   outValid,
  output logic                   linkAligned,
  output logic                   overflowErr
);
  deskewStrobe_t           strobes;
  logic [CW*NUM_LANES-1:0] laneCount;
  logic                    validReg;

  deskew_ctrl #(.NUM_LANES(NUM_LANES), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rst_n(rst_n), .linkRestart(linkRestart),
    .laneValid(laneValid), .laneChar(laneChar), .laneIsK(laneIsK),
    .laneSeqEn(laneSeqEn), .laneCount(laneCount), .strobes(strobes),
    .linkAligned(linkAligned), .overflowErr(overflowErr)
  );

  deskew_lanes #(.NUM_LANES(NUM_LANES), .DEPTH(DEPTH)) uLanes (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .laneChar(laneChar), .laneIsK(laneIsK), .laneCount(laneCount),
    .outChar(outChar), .outIsK(outIsK), .validReg(validReg)
  );

  assign outValid = validReg & ~overflowErr;
endmodule

// File: tb/tb_deskew_buffer.sv
module tb_deskew_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic linkRestart = 1'b0;
  logic [NL-1:0]   laneValid = '0;
  logic [8*NL-1:0] laneChar = '0;
  logic [NL-1:0]   laneIsK = '0;
  logic [NL-1:0]   laneSeqEn = '0;
  logic [8*NL-1:0] outChar;
  logic [NL-1:0]   outIsK;
  logic outValid, linkAligned, overflowErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  deskew_buffer #(.NUM_LANES(NL), .OCTETS_PER_FRAME(1), .SKEW_FRAMES(32)) dut (
    .clk(clk), .rst_n(rst_n), .linkRestart(linkRestart),
    .laneValid(laneValid), .laneChar(laneChar), .laneIsK(laneIsK),
    .laneSeqEn(laneSeqEn), .outChar(outChar), .outIsK(outIsK),
    .outValid(outValid), .linkAligned(linkAligned), .overflowErr(overflowErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [8:0] mq [NL][$];
  bit mWr [NL];
  bit mRel, mErr, mValidReg;
  logic [8*NL-1:0] mChar;
  logic [NL-1:0]   mK;
  bit hitV [NL];
  bit wrV [NL];
  int sz [NL];
  bit allM, rdV, dropV, fillV, relN;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n || linkRestart) begin
      for (int i = 0; i < NL; i++) begin mq[i].delete(); mWr[i] = 0; end
      mRel = 0; mErr = 0; mValidReg = 0;
    end else begin
      allM = 1; rdV = mRel && !mErr; dropV = 0; fillV = 0;
      for (int i = 0; i < NL; i++) begin
        sz[i] = mq[i].size();
        hitV[i] = laneValid[i] && laneIsK[i] && laneSeqEn[i] &&
                  laneChar[8*i +: 8] == 8'h1C && !mWr[i] && !mErr;
        wrV[i] = laneValid[i] && (mWr[i] || hitV[i]) && !mErr;
        if (!(mWr[i] || hitV[i])) allM = 0;
        if (sz[i] == 0) rdV = 0;
      end
      relN = mRel || allM;
      for (int i = 0; i < NL; i++) begin
        if (sz[i] == DEPTH || (sz[i] == DEPTH-1 && wrV[i])) fillV = 1;
        if (wrV[i] && sz[i] == DEPTH && !rdV) dropV = 1;
      end
      for (int i = 0; i < NL; i++) begin
        if (rdV) begin
          logic [8:0] e;
          e = mq[i].pop_front();
          mChar[8*i +: 8] = e[7:0];
          mK[i] = e[8];
        end
        if (wrV[i] && !(sz[i] == DEPTH && !rdV))
          mq[i].push_back({laneIsK[i], laneChar[8*i +: 8]});
        if (hitV[i]) mWr[i] = 1;
      end
      mValidReg = rdV;
      mRel = relN;
      if ((!relN && fillV) || dropV) mErr = 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareModel();
    bit ev, ea;
    ev = mValidReg && !mErr;
    ea = mRel && !mErr;
    check(outValid === ev && linkAligned === ea && overflowErr === mErr,
          "R2 R6 R8", "model flags {valid,aligned,err}",
          {61'd0, outValid, linkAligned, overflowErr}, {61'd0, ev, ea, mErr});
    if (ev)
      check(outChar === mChar && outIsK === mK, "R5", "model characters",
            {28'd0, outIsK, outChar}, {28'd0, mK, mChar});
  endtask

  task automatic restartLink();
    @(negedge clk); compareModel();
    linkRestart = 1'b1; laneValid = '0;
    @(negedge clk); compareModel();
    // R1: restart empties and clears
    check(outValid === 1'b0 && linkAligned === 1'b0 && overflowErr === 1'b0,
          "R1", "outputs after restart", {61'd0, outValid, linkAligned, overflowErr}, 64'd0);
    linkRestart = 1'b0;
  endtask

  task automatic runScen(input int d0, input int d1, input int d2, input int d3,
                         input int nSteps, input bit expOvf, input int gapStart,
                         input int gapLen, input int stopLane, input int stopAt);
    int d [NL];
    int lastMark;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    lastMark = 0;
    for (int i = 0; i < NL; i++) if (d[i] + 3 > lastMark) lastMark = d[i] + 3;
    for (int t = 0; t < nSteps; t++) begin
      @(negedge clk);
      compareModel();
      if (!expOvf && t == lastMark)
        check(linkAligned === 1'b0, "R4", "aligned before last marker edge", {63'd0, linkAligned}, 64'd0);
      if (!expOvf && t == lastMark + 1)
        check(linkAligned === 1'b1, "R4", "aligned after last marker edge", {63'd0, linkAligned}, 64'd1);
      if (!expOvf && t == lastMark + 2)
        check(outValid === 1'b1 && outChar === {NL{8'h1C}} && outIsK === {NL{1'b1}},
              "R5", "first aligned word is all /R/", {27'd0, outValid, outIsK, outChar},
              {27'd0, 1'b1, {NL{1'b1}}, {NL{8'h1C}}});
      if (gapLen >= 2 && t == gapStart + 2)
        check(outValid === 1'b0, "R6", "no read while lanes are empty", {63'd0, outValid}, 64'd0);
      for (int i = 0; i < NL; i++) begin
        int r;
        r = t - 3 - d[i];
        laneSeqEn[i] = (t >= 3);
        laneValid[i] = 1'b1;
        if (t == 1) begin            // R3: /R/ outside the sequence window
          laneChar[8*i +: 8] = 8'h1C; laneIsK[i] = 1'b1;
        end else if (t == 2) begin   // R3: 0x1C as data, not control
          laneChar[8*i +: 8] = 8'h1C; laneIsK[i] = 1'b0;
        end else if (r < 0) begin
          laneChar[8*i +: 8] = 8'hBC; laneIsK[i] = 1'b1;
        end else if (r == 0) begin
          laneChar[8*i +: 8] = 8'h1C; laneIsK[i] = 1'b1;
        end else begin
          laneChar[8*i +: 8] = 8'(r * 3 + i * 64 + 1); laneIsK[i] = 1'b0;
        end
        if (t >= gapStart && t < gapStart + gapLen) laneValid[i] = 1'b0;
        if (i == stopLane && t >= stopAt) laneValid[i] = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid === 1'b0 && linkAligned === 1'b0 && overflowErr === 1'b0,
          "R1", "outputs in reset", {61'd0, outValid, linkAligned, overflowErr}, 64'd0);
    rst_n = 1'b1;

    runScen(0, 0, 0, 0, 80, 0, 1000, 0, 9, 1000);
    restartLink();
    runScen(3, 0, 17, 9, 100, 0, 1000, 0, 9, 1000);
    restartLink();
    runScen(31, 0, 10, 5, 120, 0, 1000, 0, 9, 1000);
    // R7: maximum tolerated skew
    check(overflowErr === 1'b0 && linkAligned === 1'b1, "R7", "skew 31 aligned without error",
          {62'd0, overflowErr, linkAligned}, 64'd1);
    restartLink();
    runScen(32, 0, 0, 0, 120, 1, 1000, 0, 9, 1000);
    // R8: skew of a full buffer depth
    check(overflowErr === 1'b1 && linkAligned === 1'b0 && outValid === 1'b0, "R8",
          "skew 32 gives sticky overflow", {61'd0, overflowErr, linkAligned, outValid}, 64'd4);
    restartLink();
    runScen(0, 0, 0, 0, 120, 0, 20, 4, 1, 40);
    // R9: one lane stalls after release, others overfill
    check(overflowErr === 1'b1 && outValid === 1'b0, "R9", "write into full lane",
          {62'd0, overflowErr, outValid}, 64'd2);
    restartLink();
    runScen(5, 2, 0, 7, 60, 0, 1000, 0, 9, 1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule